// File: doc/BRIEF.md
# Pin Interrupt and Wake Status Detector

This block sits behind the input glitch filter of a bank of general-purpose pins. For each pin it watches the filtered level and, according to that pin's trigger configuration, decides on every clock whether a trigger event has occurred. An event is recorded in two sticky flags per pin. The interrupt flag is recorded only while the pin's interrupt enable is set. The wake flag is recorded only while the system is in a sleep state whose wake enable is set for that pin. Software clears either flag by pulsing the matching write-one-to-clear strobe.

Each pin reports a pending flag, which is the OR of its two sticky flags. It also reports a deliverable flag, which is the pending flag gated by the pin's mask bit. A downstream aggregator collects both. The enable bit decides whether status is captured. The mask bit decides only whether captured status is forwarded, so masking a pin never loses an event.

Each pin's two flags are held by a four-state machine:

| State | Meaning |
|---|---|
| ST_IDLE | Neither flag set |
| ST_INT | Interrupt flag only |
| ST_WAKE | Wake flag only |
| ST_BOTH | Both flags set |

On every clock the machine takes one of three named transitions:

| Transition | When it is taken |
|---|---|
| HOLD | No set event and no clear strobe changes the flags |
| CAPTURE | A qualified event sets a flag |
| CLEAR | A strobe removes a flag that no event re-sets in the same cycle |

Top module: `gpio_wk_detect`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, every status, pending and deliverable output is 0.
- R2: In edge mode (`trig_level_i`=0) with trigger code 0, a 0-to-1 change of the filtered level between two consecutive cycles sets the interrupt flag, provided interrupt enable is 1. The flag is visible one clock after the cycle in which the new level is presented.
- R3: In edge mode, trigger code 1 sets the flag on a 1-to-0 change. Code 2 sets it on either change. Code 3 never sets it.
- R4: In level mode (`trig_level_i`=1), code 0 sets the flag on every cycle the level is 1, and code 1 sets it on every cycle the level is 0. A flag cleared while its level is still active is set again. Codes 2 and 3 produce no event in level mode.
- R5: While interrupt enable is 0, no event sets the interrupt flag.
- R6: The sleep state input is coded 0 = running, 1 = light idle, 2 = suspend to memory, 3 = hibernate/off. Wake enable bit k of a pin (bit 3*pin+k) belongs to sleep state k+1. An event sets the wake flag only when the current state is nonzero and its bit is 1. The wake flag is independent of interrupt enable.
- R7: A 1 on a clear strobe clears the matching flag one clock later. If a set event for that flag occurs in the same cycle, the flag stays set.
- R8: `pend_o` is the OR of the two flags. `deliv_o` is `pend_o` ANDed with the mask bit. The mask bit has no effect on either flag.
- R9: The first clock after reset release records the level as a reference only, so no edge event is seen in that cycle even if the level is 1.
- R10: A set flag holds until its clear strobe is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_i | input | NPINS | Filtered pin levels |
| trig_level_i | input | NPINS | 1 = level trigger, 0 = edge trigger |
| pol_i | input | 2*NPINS | Trigger code per pin (bits 2p+1:2p) |
| int_en_i | input | NPINS | Interrupt status capture enable |
| int_mask_i | input | NPINS | 1 = forward pending status |
| wake_en_i | input | NSLEEP*NPINS | Wake enable per pin and sleep state |
| sleep_i | input | SLW | Current sleep state code |
| clr_int_i | input | NPINS | Write-one-to-clear for interrupt flags |
| clr_wake_i | input | NPINS | Write-one-to-clear for wake flags |
| int_sts_o | output | NPINS | Sticky interrupt flags |
| wake_sts_o | output | NPINS | Sticky wake flags |
| pend_o | output | NPINS | Pending per pin |
| deliv_o | output | NPINS | Pending and unmasked per pin |

## Verification
The properties assume that the filtered level, the configuration bits and the sleep code are stable across each clock edge. They also assume that a clear strobe is a one-cycle pulse per write. The stimulus changes every input only on the falling edge, away from the capturing edge. It draws trigger codes, modes, enables, masks, sleep codes and strobes at random from a fixed seed. Directed sequences cover clear-versus-set collisions, level re-capture after a clear, the unprimed first cycle and every sleep code.

// File: rtl/gpio_wk_pkg.sv
package gpio_wk_pkg;

    // Trigger codes
    localparam logic [1:0] POL_HIGH = 2'd0;
    localparam logic [1:0] POL_LOW  = 2'd1;
    localparam logic [1:0] POL_BOTH = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_INT  = 2'b01,
        ST_WAKE = 2'b10,
        ST_BOTH = 2'b11
    } wk_state_e;

    typedef enum logic [1:0] {
        TR_HOLD    = 2'd0,
        TR_CAPTURE = 2'd1,
        TR_CLEAR   = 2'd2
    } wk_trans_e;

endpackage

// File: rtl/gpio_wk_trig.sv
module gpio_wk_trig
    import gpio_wk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       primed_i,
    input  logic       lvl_i,
    input  logic       level_mode_i,
    input  logic [1:0] pol_i,
    output logic       event_o
);

    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign rise = primed_i &  lvl_i & ~prev_q;
    assign fall = primed_i & ~lvl_i &  prev_q;

    always_comb begin
        event_o = 1'b0;
        if (level_mode_i) begin
            unique case (pol_i)
                POL_HIGH: event_o = lvl_i;
                POL_LOW:  event_o = ~lvl_i;
                default:  event_o = 1'b0;
            endcase
        end else begin
            unique case (pol_i)
                POL_HIGH: event_o = rise;
                POL_LOW:  event_o = fall;
                POL_BOTH: event_o = rise | fall;
                default:  event_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_wk_wake_sel.sv
module gpio_wk_wake_sel #(
    parameter int NSLEEP = 3,
    parameter int SLW    = $clog2(NSLEEP + 1)
) (
    input  logic [NSLEEP-1:0] wake_en_i,
    input  logic [SLW-1:0]    sleep_i,
    output logic              wake_ok_o
);

    logic [NSLEEP-1:0] hit;

    for (genvar k = 0; k < NSLEEP; k++) begin : g_state
        localparam logic [SLW-1:0] CODE = SLW'(k + 1);
        assign hit[k] = wake_en_i[k] & (sleep_i == CODE);
    end

    assign wake_ok_o = |hit;

endmodule

// File: rtl/gpio_wk_stat_fsm.sv
module gpio_wk_stat_fsm
    import gpio_wk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_int_i,
    input  logic set_wake_i,
    input  logic clr_int_i,
    input  logic clr_wake_i,
    input  logic mask_i,
    output logic int_sts_o,
    output logic wake_sts_o,
    output logic pend_o,
    output logic deliv_o
);

    wk_state_e state_q;
    wk_state_e state_d;
    wk_trans_e trans;
    logic      keep_int;
    logic      keep_wake;
    logic      nxt_int;
    logic      nxt_wake;

    // Next state: a set in the same cycle as a clear wins
    always_comb begin
        keep_int  = 1'b0;
        keep_wake = 1'b0;
        unique case (state_q)
            ST_IDLE: begin keep_int = 1'b0; keep_wake = 1'b0; end
            ST_INT:  begin keep_int = 1'b1; keep_wake = 1'b0; end
            ST_WAKE: begin keep_int = 1'b0; keep_wake = 1'b1; end
            ST_BOTH: begin keep_int = 1'b1; keep_wake = 1'b1; end
            default: begin keep_int = 1'b0; keep_wake = 1'b0; end
        endcase
        nxt_int  = (keep_int  & ~clr_int_i)  | set_int_i;
        nxt_wake = (keep_wake & ~clr_wake_i) | set_wake_i;
        state_d  = wk_state_e'({nxt_wake, nxt_int});
        if ((nxt_int & ~keep_int) | (nxt_wake & ~keep_wake)) begin
            trans = TR_CAPTURE;
        end else if (state_d != state_q) begin
            trans = TR_CLEAR;
        end else begin
            trans = TR_HOLD;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (trans)
                TR_CAPTURE, TR_CLEAR: state_q <= state_d;
                default:              state_q <= state_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        int_sts_o  = 1'b0;
        wake_sts_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INT:  int_sts_o = 1'b1;
            ST_WAKE: wake_sts_o = 1'b1;
            ST_BOTH: begin int_sts_o = 1'b1; wake_sts_o = 1'b1; end
            default: ;
        endcase
        pend_o  = (state_q != ST_IDLE);
        deliv_o = pend_o & mask_i;
    end

endmodule

// File: rtl/gpio_wk_detect.sv
module gpio_wk_detect #(
    parameter int NPINS  = 8,
    parameter int NSLEEP = 3,
    parameter int SLW    = $clog2(NSLEEP + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS-1:0]         lvl_i,
    input  logic [NPINS-1:0]         trig_level_i,
    input  logic [2*NPINS-1:0]       pol_i,
    input  logic [NPINS-1:0]         int_en_i,
    input  logic [NPINS-1:0]         int_mask_i,
    input  logic [NSLEEP*NPINS-1:0]  wake_en_i,
    input  logic [SLW-1:0]           sleep_i,
    input  logic [NPINS-1:0]         clr_int_i,
    input  logic [NPINS-1:0]         clr_wake_i,
    output logic [NPINS-1:0]         int_sts_o,
    output logic [NPINS-1:0]         wake_sts_o,
    output logic [NPINS-1:0]         pend_o,
    output logic [NPINS-1:0]         deliv_o
);

    logic primed_q;

    // The first clock after reset only loads the edge reference
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic evt;
        logic wake_ok;

        gpio_wk_trig i_trig (
            .clk          (clk),
            .rst_n        (rst_n),
            .primed_i     (primed_q),
            .lvl_i        (lvl_i[p]),
            .level_mode_i (trig_level_i[p]),
            .pol_i        (pol_i[2*p +: 2]),
            .event_o      (evt)
        );

        gpio_wk_wake_sel #(.NSLEEP(NSLEEP), .SLW(SLW)) i_wsel (
            .wake_en_i (wake_en_i[NSLEEP*p +: NSLEEP]),
            .sleep_i   (sleep_i),
            .wake_ok_o (wake_ok)
        );

        gpio_wk_stat_fsm i_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_int_i  (evt & int_en_i[p]),
            .set_wake_i (evt & wake_ok),
            .clr_int_i  (clr_int_i[p]),
            .clr_wake_i (clr_wake_i[p]),
            .mask_i     (int_mask_i[p]),
            .int_sts_o  (int_sts_o[p]),
            .wake_sts_o (wake_sts_o[p]),
            .pend_o     (pend_o[p]),
            .deliv_o    (deliv_o[p])
        );
    end

endmodule

// File: rtl/gpio_wk_detect_chk.sv
module gpio_wk_detect_chk #(
    parameter int NPINS  = 8,
    parameter int NSLEEP = 3,
    parameter int SLW    = $clog2(NSLEEP + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPINS-1:0]        lvl_i,
    input logic [NPINS-1:0]        trig_level_i,
    input logic [2*NPINS-1:0]      pol_i,
    input logic [NPINS-1:0]        int_en_i,
    input logic [NPINS-1:0]        int_mask_i,
    input logic [NSLEEP*NPINS-1:0] wake_en_i,
    input logic [SLW-1:0]          sleep_i,
    input logic [NPINS-1:0]        clr_int_i,
    input logic [NPINS-1:0]        clr_wake_i,
    input logic [NPINS-1:0]        int_sts_o,
    input logic [NPINS-1:0]        wake_sts_o,
    input logic [NPINS-1:0]        pend_o,
    input logic [NPINS-1:0]        deliv_o
);

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        // R10
        int_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int_sts_o[p] && !clr_int_i[p]) |=> int_sts_o[p]);
        // R10
        wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_sts_o[p] && !clr_wake_i[p]) |=> wake_sts_o[p]);
        // R7
        int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_int_i[p] && !int_en_i[p]) |=> !int_sts_o[p]);
        // R7
        wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wake_i[p] && sleep_i == '0) |=> !wake_sts_o[p]);
        // R5
        int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!int_sts_o[p] && !int_en_i[p]) |=> !int_sts_o[p]);
        // R6
        wake_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wake_sts_o[p] && sleep_i == '0) |=> !wake_sts_o[p]);
        // R6
        wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wake_sts_o[p] && wake_en_i[NSLEEP*p +: NSLEEP] == '0) |=> !wake_sts_o[p]);
        // R4
        level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int_en_i[p] && trig_level_i[p] && pol_i[2*p +: 2] == 2'd0 && lvl_i[p])
            |=> int_sts_o[p]);
        // R8
        pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_o[p] == (int_sts_o[p] || wake_sts_o[p]));
        // R8
        deliv_chk: assert property (@(posedge clk) disable iff (!rst_n)
            deliv_o[p] == (pend_o[p] && int_mask_i[p]));
    end

endmodule

bind gpio_wk_detect gpio_wk_detect_chk #(.NPINS(NPINS), .NSLEEP(NSLEEP), .SLW(SLW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl_i        (lvl_i),
    .trig_level_i (trig_level_i),
    .pol_i        (pol_i),
    .int_en_i     (int_en_i),
    .int_mask_i   (int_mask_i),
    .wake_en_i    (wake_en_i),
    .sleep_i      (sleep_i),
    .clr_int_i    (clr_int_i),
    .clr_wake_i   (clr_wake_i),
    .int_sts_o    (int_sts_o),
    .wake_sts_o   (wake_sts_o),
    .pend_o       (pend_o),
    .deliv_o      (deliv_o)
);

// File: tb/test_gpio_wk_detect.sv
module test_gpio_wk_detect;

    localparam int  NP     = 8;
    localparam int  NS     = 3;
    localparam int  SW     = 2;
    localparam time PERIOD = 10ns;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        lvl = '0;
    logic [NP-1:0]        tlev = '0;
    logic [2*NP-1:0]      pol = '0;
    logic [NP-1:0]        ien = '0;
    logic [NP-1:0]        imask = '0;
    logic [NS*NP-1:0]     wen = '0;
    logic [SW-1:0]        slp = '0;
    logic [NP-1:0]        cint = '0;
    logic [NP-1:0]        cwake = '0;
    logic [NP-1:0]        int_sts, wake_sts, pend, deliv;

    logic [NP-1:0] m_prev, m_int, m_wake;
    logic          m_primed;
    int            n_run = 0;
    int            n_fail = 0;

    gpio_wk_detect #(.NPINS(NP), .NSLEEP(NS), .SLW(SW)) i_gpio_wk_detect (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .trig_level_i(tlev), .pol_i(pol),
        .int_en_i(ien), .int_mask_i(imask), .wake_en_i(wen), .sleep_i(slp),
        .clr_int_i(cint), .clr_wake_i(cwake), .int_sts_o(int_sts),
        .wake_sts_o(wake_sts), .pend_o(pend), .deliv_o(deliv)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic exp_event(int p);
        logic [1:0] c = pol[2*p +: 2];
        if (tlev[p]) return (c == 2'd0) ? lvl[p] : (c == 2'd1) ? !lvl[p] : 1'b0;
        if (!m_primed) return 1'b0;
        case (c)
            2'd0: return lvl[p] && !m_prev[p];
            2'd1: return !lvl[p] && m_prev[p];
            2'd2: return lvl[p] != m_prev[p];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_wake_ok(int p);
        if (slp == 0) return 1'b0;
        return wen[NS*p + int'(slp) - 1];
    endfunction

    task automatic chk(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "int_sts", int_sts, m_int);
        chk(tag, "wake_sts", wake_sts, m_wake);
        chk(tag, "pend", pend, m_int | m_wake);
        chk(tag, "deliv", deliv, (m_int | m_wake) & imask);
    endtask

    // Inputs are set after a falling edge; advance one clock and compare
    task automatic step(string tag);
        logic [NP-1:0] ni, nw;
        for (int p = 0; p < NP; p++) begin
            logic e = exp_event(p);
            ni[p] = (m_int[p] && !cint[p]) || (e && ien[p]);
            nw[p] = (m_wake[p] && !cwake[p]) || (e && exp_wake_ok(p));
        end
        @(posedge clk);
        #1;
        m_int = ni;
        m_wake = nw;
        m_prev = lvl;
        m_primed = 1'b1;
        check_all(tag);
        @(negedge clk);
        cint = '0;
        cwake = '0;
    endtask

    task automatic cfg_all(logic lm, logic [1:0] c, logic en, logic mk);
        tlev = {NP{lm}};
        pol = {NP{c}};
        ien = {NP{en}};
        imask = {NP{mk}};
    endtask

    task automatic clear_everything();
        cint = '1;
        cwake = '1;
        ien = '0;
        wen = '0;
        tlev = '0;
        pol = {NP{2'd3}};
        step("R7");
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_prev = '0; m_int = '0; m_wake = '0; m_primed = 1'b0;
        // R9: level high during reset with rising-edge trigger
        lvl = '1;
        cfg_all(1'b0, 2'd0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step("R9");
        step("R1");

        // R2 rising edge
        lvl = '0; step("R2");
        lvl = '1; step("R2");
        lvl = '1; step("R10");
        // R8 masking keeps status
        imask = '0; step("R8");
        imask = 8'hA5; step("R8");
        // R7 clear without event
        cint = '1; step("R7");
        // R3 falling
        cfg_all(1'b0, 2'd1, 1'b1, 1'b1);
        lvl = '0; step("R3");
        cint = '1; step("R7");
        // R3 both edges with collision clear
        cfg_all(1'b0, 2'd2, 1'b1, 1'b1);
        lvl = '1; cint = '1; step("R7");
        lvl = '0; cint = '1; step("R3");
        cint = '1; step("R7");
        // R3 code 3 never triggers
        cfg_all(1'b0, 2'd3, 1'b1, 1'b1);
        lvl = '1; step("R3");
        lvl = '0; step("R3");
        // R4 level mode
        cfg_all(1'b1, 2'd0, 1'b1, 1'b1);
        lvl = 8'h0F; step("R4");
        cint = '1; step("R4");
        pol = {NP{2'd1}}; cint = '1; step("R4");
        pol = {NP{2'd2}}; cint = '1; step("R4");
        pol = {NP{2'd3}}; step("R4");
        // R5 enable off
        clear_everything();
        cfg_all(1'b1, 2'd0, 1'b0, 1'b1);
        lvl = '1; step("R5");
        // R6 every sleep code
        for (int s = 0; s < 4; s++) begin
            clear_everything();
            cfg_all(1'b1, 2'd0, 1'b0, 1'b1);
            wen = {NP{3'b101}} ^ 24'h00F0F0;
            slp = SW'(s);
            lvl = '1;
            step("R6");
            cwake = '1; step("R6");
        end
        slp = '0;
        clear_everything();

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            lvl   = NP'($urandom);
            tlev  = NP'($urandom) & NP'($urandom);
            pol   = (2*NP)'($urandom);
            ien   = NP'($urandom);
            imask = NP'($urandom);
            wen   = (NS*NP)'($urandom);
            slp   = SW'($urandom);
            cint  = NP'($urandom) & NP'($urandom);
            cwake = NP'($urandom) & NP'($urandom);
            step("R3 R4 R6 R7 R8 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule